// File: doc/BRIEF.md
# Packet-Driven Record Transfer Engine

This engine moves one whole record between memory and a single peripheral data channel while the processor is held. A command gives a direction and a 2-bit packet number. The number picks one of four four-word control packets in memory. The engine reads the packet and hands the packet's device command word to the device. It then moves 16-bit words one at a time, at the pace the device sets, between the device and consecutive memory addresses.

A transfer ends in one of two ways: the word at the packet's final address has been moved, or the device flags a word as its last. The engine then writes the address of the last word it moved into the fourth word of the packet and pulses `done` for one cycle. A command that arrives while a transfer is running is refused.

Top module: `rec_xfer_engine`

## Requirements
- R1: While reset is held, and after it is released with no command, `busy`, `done`, `cmd_err`, `mem_req`, `dev_cmd_valid` and `dev_ack` are all 0.
- R2: The packet base is 496 + 4 × `cmd_pkt` (pkt 0→496, 1→500, 2→504, 3→508). The first three memory reads of a transfer are base+0 (device command), base+1 (final address) and base+2 (starting address), in that order, one per cycle.
- R3: The device command word (packet word 0) appears on `dev_cmd` with `dev_cmd_valid` high for exactly one cycle per transfer, before any data word is moved.
- R4: With `cmd_dir`=0 (input), each cycle in which `dev_rdy` is high moves one word: `dev_ack` is high, and `dev_rdata` is written to the current address, starting at the starting address and rising by one per word.
- R5: With `cmd_dir`=1 (output), the engine reads the current address, then offers that word on `dev_wdata` with `dev_wvalid` high until `dev_rdy` is seen; `dev_ack` marks the move. Addresses start at the starting address and rise by one per word.
- R6: No word is moved after the word at the final address.
- R7: A word moved with `dev_last` high is the last word of the record. For a short record the written-back address is below the final address.
- R8: After the last data word, packet word 3 (base+3) is written exactly once, with the zero-extended address of the last word moved. When `dev_last` comes with the word at the final address, the written value is the final address.
- R9: `done` is high for exactly one cycle, the cycle after the write-back. In the next cycle `busy` is 0.
- R10: `busy` is 1 from the cycle after a command is accepted (`cmd_valid` with `busy` low) through the `done` cycle.
- R11: A `cmd_valid` while `busy` is 1 raises `cmd_err` in the same cycle and has no other effect: the running transfer completes unchanged, and no memory access follows its `done`.
- R12: A record whose starting address equals its final address moves exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start request |
| cmd_dir | input | 1 | 0: device to memory, 1: memory to device |
| cmd_pkt | input | 2 | Control packet number |
| cmd_err | output | 1 | Request refused because the engine is busy |
| busy | output | 1 | Transfer running; holds the processor |
| done | output | 1 | One-cycle end-of-record pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| dev_cmd_valid | output | 1 | Device command word valid |
| dev_cmd | output | DW | Device command word |
| dev_rdy | input | 1 | Device can move a word this cycle |
| dev_last | input | 1 | Word moved this cycle ends the record |
| dev_rdata | input | DW | Word from the device (input direction) |
| dev_wvalid | output | 1 | Word offered to the device (output direction) |
| dev_wdata | output | DW | Word to the device |
| dev_ack | output | 1 | A data word moves this cycle |

## Verification
The device's last-word flag and the arrival at the final address can happen on the same word. If the engine checked them in separate paths, it could write back twice or move one word too many. The bench sets the flag on exactly the word at the final address, in both directions. It then expects exactly one write-back, carrying the final address, and no `dev_ack` after that word. A second concurrent case is a refused command that lands in the middle of a running transfer. The bench judges it by `cmd_err` in that cycle, an undisturbed write sequence and write-back, and a silent memory port after `done`.

// File: rtl/rec_xfer_engine.sv
module rec_xfer_engine #(
  parameter int AW       = 10,
  parameter int DW       = 16,
  parameter int PKT_BASE = 496
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_dir,
  input  logic [1:0]    cmd_pkt,
  output logic          cmd_err,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_cmd_valid,
  output logic [DW-1:0] dev_cmd,
  input  logic          dev_rdy,
  input  logic          dev_last,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_wvalid,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_ack
);

  localparam logic [AW-1:0] BASE = AW'(PKT_BASE);

  typedef enum logic [3:0] {
    S_IDLE, S_P0, S_P1, S_P2, S_P3, S_IN, S_ORD, S_OLAT, S_OOFF, S_WB, S_FIN
  } st_t;

  st_t           st;
  logic          dir_q;
  logic [1:0]    pkt_q;
  logic [DW-1:0] cmd_q;
  logic [DW-1:0] out_q;
  logic [AW-1:0] fin_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] pbase;
  logic          cmd_sent;
  logic          at_end;

  assign pbase         = BASE + AW'({pkt_q, 2'b00});
  assign at_end        = dev_last || (addr_q == fin_q);
  assign busy          = (st != S_IDLE);
  assign done          = (st == S_FIN);
  assign cmd_err       = cmd_valid && busy;
  assign dev_cmd_valid = (st == S_P3);
  assign dev_cmd       = cmd_q;
  assign dev_wvalid    = (st == S_OOFF);
  assign dev_wdata     = out_q;
  assign dev_ack       = dev_rdy && ((st == S_IN) || (st == S_OOFF));

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = dev_rdata;
    case (st)
      S_P0:  begin mem_req = 1'b1; mem_addr = pbase; end
      S_P1:  begin mem_req = 1'b1; mem_addr = pbase + AW'(1); end
      S_P2:  begin mem_req = 1'b1; mem_addr = pbase + AW'(2); end
      S_IN:  begin mem_req = dev_rdy; mem_we = 1'b1; end
      S_ORD: mem_req = 1'b1;
      S_WB:  begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = pbase + AW'(3);
        mem_wdata = DW'(addr_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dir_q    <= 1'b0;
      pkt_q    <= '0;
      cmd_q    <= '0;
      out_q    <= '0;
      fin_q    <= '0;
      addr_q   <= '0;
      cmd_sent <= 1'b0;
    end else begin
      if (dev_cmd_valid) cmd_sent <= 1'b1;
      case (st)
        S_IDLE: begin
          cmd_sent <= 1'b0;
          if (cmd_valid) begin
            dir_q <= cmd_dir;
            pkt_q <= cmd_pkt;
            st    <= S_P0;
          end
        end
        S_P0: st <= S_P1;
        S_P1: begin cmd_q <= mem_rdata; st <= S_P2; end
        S_P2: begin fin_q <= mem_rdata[AW-1:0]; st <= S_P3; end
        S_P3: begin
          addr_q <= mem_rdata[AW-1:0];
          st     <= dir_q ? S_ORD : S_IN;
        end
        S_IN: if (dev_rdy) begin
          if (at_end) st <= S_WB;
          else addr_q <= addr_q + 1'b1;
        end
        S_ORD:  st <= S_OLAT;
        S_OLAT: begin out_q <= mem_rdata; st <= S_OOFF; end
        S_OOFF: if (dev_rdy) begin
          if (at_end) st <= S_WB;
          else begin
            addr_q <= addr_q + 1'b1;
            st     <= S_ORD;
          end
        end
        S_WB:  st <= S_FIN;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> cmd_sent);

  // R6
  final_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && addr_q == fin_q) |=> (!dev_ack && !dev_wvalid));

  // R7
  last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && dev_last) |=> (!dev_ack && !dev_wvalid));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> ($stable(pkt_q) && $stable(dir_q)));

endmodule

// File: tb/rec_xfer_engine_test.sv
`timescale 1ns/100ps
module rec_xfer_engine_test;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_dir = 1'b0;
  logic [1:0] cmd_pkt = '0;
  logic cmd_err, busy, done, mem_req, mem_we, dev_cmd_valid, dev_wvalid, dev_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_cmd, dev_wdata, dev_rdata;
  logic dev_rdy, dev_last;

  always #2.5 clk = ~clk;

  rec_xfer_engine #(.AW(AW), .DW(DW), .PKT_BASE(496)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_pkt(cmd_pkt), .cmd_err(cmd_err), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_cmd_valid(dev_cmd_valid), .dev_cmd(dev_cmd), .dev_rdy(dev_rdy),
    .dev_last(dev_last), .dev_rdata(dev_rdata), .dev_wvalid(dev_wvalid),
    .dev_wdata(dev_wdata), .dev_ack(dev_ack));

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] rd_q = '0;
  assign mem_rdata = rd_q;
  always @(posedge clk) if (mem_req) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else rd_q <= mem[mem_addr];
  end

  int  k = 0;
  bit  k_clr = 0;
  int  last_at = -1;
  bit  rdy_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  assign dev_rdy   = rdy_mode ? lfsr[0] : 1'b1;
  assign dev_rdata = 16'hC000 + k[15:0];
  assign dev_last  = (k == last_at);
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (k_clr) k <= 0;
    else if (dev_ack) k <= k + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  int exp_wa[$], exp_wd[$], exp_out[$];
  int cur_base = 0, cur_start = 0, exp_cmd = 0, rd_idx = 0;
  bit running = 0, cmd_seen = 0, prev_done = 0, done_seen = 0;
  int done_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      chk(!busy && !done && !cmd_err && !mem_req && !dev_cmd_valid && !dev_ack,
          "R1 reset outputs", {busy, done, mem_req, dev_ack}, 0);
    end else begin
      if (prev_done) begin
        prev_done = 0;
        running = 0;
        // R9
        chk(!busy && !done, "R9 idle after done", {busy, done}, 0);
      end
      // R10
      if (busy != running) chk(0, "R10 busy window", busy, running);
      if (mem_req && !running) chk(0, "R11 memory access outside transfer", mem_addr, -1);
      if (mem_req && !mem_we) begin
        if (rd_idx < 3) chk(mem_addr == cur_base + rd_idx, "R2 packet read address", mem_addr, cur_base + rd_idx);
        else chk(mem_addr == cur_start + rd_idx - 3, "R5 data read address", mem_addr, cur_start + rd_idx - 3);
        rd_idx++;
      end
      if (mem_req && mem_we) begin
        if (exp_wa.size() == 0) chk(0, "R8 unexpected write", mem_addr, -1);
        else begin
          int ea, ed;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
          chk(mem_addr == ea, "R4 write address", mem_addr, ea);
          chk(mem_wdata == ed[15:0], "R4 write data", mem_wdata, ed);
        end
      end
      if (dev_cmd_valid) begin
        chk(!cmd_seen, "R3 single command issue", cmd_seen, 0);
        chk(dev_cmd == exp_cmd[15:0], "R3 command word", dev_cmd, exp_cmd);
        cmd_seen = 1;
      end
      if (dev_ack) begin
        if (!cmd_seen) chk(0, "R3 data before command", 0, 1);
        if (dev_wvalid) begin
          if (exp_out.size() == 0) chk(0, "R6 extra output word", dev_wdata, -1);
          else begin
            int eo;
            eo = exp_out.pop_front();
            chk(dev_wdata == eo[15:0], "R5 output word", dev_wdata, eo);
          end
        end
      end
      if (done) begin
        done_cnt++;
        prev_done = 1;
        done_seen = 1;
        chk(exp_wa.size() == 0 && exp_out.size() == 0, "R8 all words and write-back before done",
            exp_wa.size() + exp_out.size(), 0);
      end
    end
  end

  always @(posedge clk) if (cyc > 100000 && !finished) begin
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run(input bit dir, input int pkt, input int start, input int fin,
                     input int last, input bit rmode, input bit inject, input string tag);
    int base, n;
    base = 496 + 4 * pkt;
    n = fin - start + 1;
    if (last >= 0 && last < n) n = last + 1;
    exp_cmd = 16'h8100 + pkt * 16 + (dir ? 8 : 0);
    mem[base] = exp_cmd[15:0];
    mem[base+1] = fin[15:0];
    mem[base+2] = start[15:0];
    mem[base+3] = 16'hFFFF;
    for (int i = 0; i < fin - start + 1; i++) mem[start+i] = 16'h5000 + 16'(i * 7 + pkt);
    exp_wa.delete(); exp_wd.delete(); exp_out.delete();
    for (int i = 0; i < n; i++) begin
      if (dir) exp_out.push_back(int'(mem[start+i]));
      else begin exp_wa.push_back(start + i); exp_wd.push_back(16'hC000 + i); end
    end
    exp_wa.push_back(base + 3); exp_wd.push_back(start + n - 1);
    cur_base = base; cur_start = start; rd_idx = 0; cmd_seen = 0;
    done_seen = 0; done_cnt = 0;
    last_at = last; rdy_mode = rmode;
    k_clr = 1;
    @(posedge clk); #1;
    k_clr = 0;
    cmd_valid = 1; cmd_dir = dir; cmd_pkt = pkt[1:0];
    @(posedge clk); #1;
    cmd_valid = 0;
    running = 1;
    fork
      begin
        while (!done_seen) @(posedge clk);
      end
      begin
        if (inject) begin
          repeat (8) @(posedge clk);
          #1 cmd_valid = 1; cmd_dir = ~dir; cmd_pkt = ~pkt[1:0];
          @(negedge clk);
          // R11
          chk(cmd_err == 1'b1, "R11 refusal flag", cmd_err, 1);
          @(posedge clk); #1 cmd_valid = 0;
        end
      end
    join
    repeat (6) @(posedge clk);
    #1;
    // R8
    chk(mem[base+3] == 16'(start + n - 1), {"R8 write-back ", tag}, mem[base+3], start + n - 1);
    chk(done_cnt == 1, {"R9 done count ", tag}, done_cnt, 1);
    chk(cmd_seen, {"R3 command seen ", tag}, cmd_seen, 1);
    if (!dir)
      for (int i = 0; i < n; i++)
        if (mem[start+i] != 16'hC000 + 16'(i)) chk(0, {"R4 stored word ", tag}, mem[start+i], 16'hC000 + i);
    if (!dir && n < fin - start + 1)
      chk(mem[start+n] == 16'h5000 + 16'(n * 7 + pkt), {"R7 word past last untouched ", tag},
          mem[start+n], 16'h5000 + n * 7 + pkt);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    // R4 R6 full input record
    run(0, 0, 20, 27, -1, 0, 0, "in full");
    // R5 R6 output, paced device
    run(1, 1, 100, 109, -1, 1, 0, "out paced");
    // R7 short input record
    run(0, 2, 200, 230, 4, 1, 0, "in short");
    // R7 R8 last flag on final word, output
    run(1, 3, 300, 305, 5, 0, 0, "out same-cycle");
    // R12 single word both directions
    run(0, 1, 400, 400, -1, 0, 0, "in single");
    run(1, 0, 50, 50, -1, 1, 0, "out single");
    // R11 refusal mid-transfer, plus same-cycle end on input
    run(0, 3, 600, 640, 40, 1, 1, "in refused");
    // R7 output terminated on first word
    run(1, 2, 700, 720, 0, 1, 0, "out first-last");
    repeat (10) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule